// File: doc/BRIEF.md
# Third-Order Fractional-N Division Ratio Modulator

This block produces, once per phase-detector reference cycle, the division ratio that a multi-modulus feedback counter applies on that cycle. A 12-bit integer word and a 25-bit fraction word set the target ratio. The output changes from cycle to cycle, but its long-term mean equals integer + fraction / 2^25. The modulus is a fixed power of two, so no modulus word is needed. The block is clocked by the reference-cycle clock, so it takes one step on every rising edge.

Three 25-bit accumulators are chained in a cascaded first-order (1-1-1) structure. The overflow bit of the first accumulator is used as it is. The overflow of the second passes through a first difference and the overflow of the third through a second difference. The sum of the three forms a signed offset in the range -3 to +4, which is added to the integer word and registered. Loading the main integer/fraction register normally clears all modulator state, so every new setting begins from a known phase. A disable control stops that clear. A separate hold input keeps the modulator at zero for as long as it is asserted.

Top module: `frac_sdm_top`

## Requirements
- R1: While rst_n is low, divOut is 0 and all accumulators and overflow history are cleared.
- R2: After a clear with fracWord = 0, divOut equals intWord on every cycle. divOut is registered, so a change of intWord appears on divOut at the next rising edge.
- R3: On every cycle, divOut minus the intWord applied at the previous edge lies within -3 to +4.
- R4: Over N consecutive outputs that follow a clear, the sum of (divOut − intWord) is within 4 of floor(fracWord·N / 2^25). The modulus is fixed at 2^25, so fracWord = 2^25−1 yields a mean just below intWord+1.
- R5: With noClearOnLoad = 0, a cycle with loadStrobe = 1 clears all modulator state. divOut equals intWord at that edge, and the outputs that follow repeat the sequence produced after any other clear.
- R6: With noClearOnLoad = 1, loadStrobe has no effect: the output sequence is identical to a run without the strobe.
- R7: While counterHold = 1, the accumulators are held at zero and divOut equals intWord. After release, the output sequence matches the one that follows a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-cycle clock; the modulator steps once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| intWord | input | 12 | Integer part of the division ratio (23 to 4095 in use) |
| fracWord | input | 25 | Fraction numerator over the fixed modulus 2^25 |
| loadStrobe | input | 1 | One-cycle pulse marking a load of the main integer/fraction register |
| noClearOnLoad | input | 1 | 1 = loadStrobe leaves the modulator state untouched |
| counterHold | input | 1 | 1 = hold the accumulators at zero and output intWord |
| divOut | output | 13 | Division ratio for this cycle, intWord plus offset |

## Verification
The hardest thing to observe from the ports is whether a load actually cleared the state or left it alone. The state sits in three wide accumulators that the output reveals only through a few overflow bits. The stimulus records a reference output sequence right after a clear. It then lets the modulator run into an arbitrary phase and pulses the load strobe. The outputs that follow must either replay the reference sequence (clear enabled) or match, cycle for cycle, a second run in which no strobe was given (clear disabled). The long-run mean is checked against exact integer arithmetic on the fraction, at a midpoint fraction, an irregular fraction, the smallest fraction and the largest fraction.

// File: rtl/frac_sdm_pkg.sv
package frac_sdm_pkg;
  typedef struct packed {
    logic clearState;
    logic holdState;
  } sdmStrobe_t;
endpackage

// File: rtl/frac_sdm_ctrl.sv
module frac_sdm_ctrl
  import frac_sdm_pkg::*;
(
  input  logic       loadStrobe,
  input  logic       noClearOnLoad,
  input  logic       counterHold,
  output sdmStrobe_t strobes
);
  always_comb begin
    strobes.clearState = loadStrobe & ~noClearOnLoad;
    strobes.holdState  = counterHold;
  end
endmodule

// File: rtl/frac_sdm_path.sv
module frac_sdm_path
  import frac_sdm_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  intWord,
  input  logic [FRAC_W-1:0] fracWord,
  input  sdmStrobe_t        strobes,
  output logic [INT_W:0]    divOut
);
  localparam int STAGES = 3;
  localparam int OUT_W  = INT_W + 1;
  localparam int OFS_W  = 4;

  logic [FRAC_W-1:0] accQ  [STAGES];
  logic [FRAC_W-1:0] addIn [STAGES];
  logic [FRAC_W:0]   sumW  [STAGES];
  logic              zeroState;

  assign zeroState = strobes.clearState | strobes.holdState;
  assign addIn[0]  = fracWord;

  // Cascade of accumulators: each adds the new residue of the one before.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g > 0) begin : g_link
      assign addIn[g] = sumW[g-1][FRAC_W-1:0];
    end
    assign sumW[g] = {1'b0, accQ[g]} + {1'b0, addIn[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         accQ[g] <= '0;
      else if (zeroState) accQ[g] <= '0;
      else                accQ[g] <= sumW[g][FRAC_W-1:0];
    end
  end

  // Overflow history used for the difference terms.
  logic c1Q, c2Q, c2QQ, c3Q, c3QQ, c3QQQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || zeroState) begin
      c1Q <= 1'b0; c2Q <= 1'b0; c2QQ <= 1'b0;
      c3Q <= 1'b0; c3QQ <= 1'b0; c3QQQ <= 1'b0;
    end else begin
      c1Q   <= sumW[0][FRAC_W];
      c2Q   <= sumW[1][FRAC_W];
      c2QQ  <= c2Q;
      c3Q   <= sumW[2][FRAC_W];
      c3QQ  <= c3Q;
      c3QQQ <= c3QQ;
    end
  end

  // y = c1 + (1 - z^-1) c2 + (1 - z^-1)^2 c3, in a 4-bit two's complement.
  logic [OFS_W-1:0] offsetW;
  logic [OUT_W-1:0] nextDiv;
  always_comb begin
    offsetW = {3'b000, c1Q} + {3'b000, c2Q} - {3'b000, c2QQ}
            + {3'b000, c3Q} - {2'b00, c3QQ, 1'b0} + {3'b000, c3QQQ};
    nextDiv = {1'b0, intWord} + {{(OUT_W-OFS_W){offsetW[OFS_W-1]}}, offsetW};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         divOut <= '0;
    else if (zeroState) divOut <= {1'b0, intWord};
    else                divOut <= nextDiv;
  end
endmodule

// File: rtl/frac_sdm_top.sv
module frac_sdm_top
  import frac_sdm_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  intWord,
  input  logic [FRAC_W-1:0] fracWord,
  input  logic              loadStrobe,
  input  logic              noClearOnLoad,
  input  logic              counterHold,
  output logic [INT_W:0]    divOut
);
  sdmStrobe_t strobes;

  frac_sdm_ctrl u_ctrl (
    .loadStrobe    (loadStrobe),
    .noClearOnLoad (noClearOnLoad),
    .counterHold   (counterHold),
    .strobes       (strobes)
  );

  frac_sdm_path #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .intWord  (intWord),
    .fracWord (fracWord),
    .strobes  (strobes),
    .divOut   (divOut)
  );
endmodule

// File: rtl/frac_sdm_checker.sv
module frac_sdm_checker #(
  parameter int INT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [INT_W-1:0] intWord,
  input logic             loadStrobe,
  input logic             noClearOnLoad,
  input logic             counterHold,
  input logic [INT_W:0]   divOut
);
  logic primed;
  logic seenEdge = 1'b0;

  always_ff @(posedge clk) seenEdge <= 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R1: reset leaves the output at zero
  a_r1_reset_zero: assert property (@(posedge clk)
    (seenEdge && $past(!rst_n) && !rst_n) |-> divOut == '0);

  // R3: instantaneous offset within -3..+4
  a_r3_offset_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (($signed({1'b0, divOut}) - $signed({2'b00, $past(intWord)})) >= -3 &&
                ($signed({1'b0, divOut}) - $signed({2'b00, $past(intWord)})) <= 4));

  // R5: a clearing load gives exactly the integer word
  a_r5_clear_int: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(loadStrobe && !noClearOnLoad)) |-> divOut == {1'b0, $past(intWord)});

  // R7: hold forces the integer word
  a_r7_hold_int: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(counterHold)) |-> divOut == {1'b0, $past(intWord)});
endmodule

bind frac_sdm_top frac_sdm_checker #(.INT_W(INT_W)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .intWord       (intWord),
  .loadStrobe    (loadStrobe),
  .noClearOnLoad (noClearOnLoad),
  .counterHold   (counterHold),
  .divOut        (divOut)
);

// File: tb/frac_sdm_top_tb.sv
module frac_sdm_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] intWord = 12'd23;
  logic [24:0] fracWord = '0;
  logic        loadStrobe = 1'b0;
  logic        noClearOnLoad = 1'b0;
  logic        counterHold = 1'b0;
  logic [12:0] divOut;

  int checkCount = 0;
  int failCount  = 0;
  int seqRef [0:63];
  int seqCmp [0:63];

  frac_sdm_top u_dut (
    .clk(clk), .rst_n(rst_n), .intWord(intWord), .fracWord(fracWord),
    .loadStrobe(loadStrobe), .noClearOnLoad(noClearOnLoad),
    .counterHold(counterHold), .divOut(divOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Clearing load; on return divOut shows the clear edge (equals intWord).
  task automatic doClear(input int iv, input int fv);
    intWord = 12'(iv); fracWord = 25'(fv);
    noClearOnLoad = 1'b0; loadStrobe = 1'b1;
    tick();
    loadStrobe = 1'b0;
  endtask

  task automatic recordSeq(input int n, input bit toRef);
    for (int k = 0; k < n; k++) begin
      tick();
      if (toRef) seqRef[k] = int'(divOut);
      else       seqCmp[k] = int'(divOut);
    end
  endtask

  task automatic compareSeq(input int n, input string req);
    int firstBad = -1;
    for (int k = 0; k < n; k++)
      if (seqRef[k] != seqCmp[k] && firstBad < 0) firstBad = k;
    if (firstBad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, seqCmp[firstBad], seqRef[firstBad]);
  endtask

  task automatic testReset();
    tick(); tick();
    check(divOut == 13'd0, "R1", divOut, 0);
    rst_n = 1'b1;
    tick();
    check(divOut == 13'd23, "R1 first step after reset", divOut, 23);
  endtask

  task automatic testZeroFrac();
    int bad = 0;
    doClear(23, 0);
    for (int k = 0; k < 50; k++) begin
      tick();
      if (divOut != 13'd23) bad++;
    end
    check(bad == 0, "R2 zero fraction gives INT", bad, 0);
    intWord = 12'd4095;
    tick();
    check(divOut == 13'd4095, "R2 INT change next edge", divOut, 4095);
  endtask

  // R4 mean over n outputs and R3 bounds on each one.
  task automatic testMean(input int iv, input int fv, input int n);
    longint sum = 0;
    longint expv;
    int outOfRange = 0;
    int ofs;
    doClear(iv, fv);
    for (int k = 0; k < n; k++) begin
      tick();
      ofs = int'(divOut) - iv;
      if (ofs < -3 || ofs > 4) outOfRange++;
      sum += ofs;
    end
    expv = (longint'(fv) * n) >>> 25;
    check(sum - expv <= 4 && expv - sum <= 4, "R4 long-run mean", sum, expv);
    check(outOfRange == 0, "R3 offset bounds", outOfRange, 0);
  endtask

  task automatic testClearOnLoad();
    doClear(100, 25'h0ABCDE);
    recordSeq(40, 1'b1);
    recordSeq(37, 1'b0);
    loadStrobe = 1'b1;
    tick();
    loadStrobe = 1'b0;
    check(divOut == 13'd100, "R5 load edge gives INT", divOut, 100);
    recordSeq(40, 1'b0);
    compareSeq(40, "R5 sequence restarts");
  endtask

  task automatic testNoClear();
    doClear(300, 25'h1234567);
    recordSeq(64, 1'b1);
    doClear(300, 25'h1234567);
    for (int k = 0; k < 20; k++) begin
      tick();
      seqCmp[k] = int'(divOut);
    end
    noClearOnLoad = 1'b1; loadStrobe = 1'b1;
    for (int k = 20; k < 64; k++) begin
      tick();
      seqCmp[k] = int'(divOut);
      loadStrobe = 1'b0;
    end
    noClearOnLoad = 1'b0;
    compareSeq(64, "R6 load ignored");
  endtask

  task automatic testHold();
    int bad = 0;
    doClear(200, 25'h0555555);
    recordSeq(40, 1'b1);
    recordSeq(30, 1'b0);
    counterHold = 1'b1;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (divOut != 13'd200) bad++;
    end
    check(bad == 0, "R7 hold gives INT", bad, 0);
    counterHold = 1'b0;
    recordSeq(40, 1'b0);
    compareSeq(40, "R7 release restarts sequence");
  endtask

  initial begin
    tick();
    testReset();
    testZeroFrac();
    testMean(1000, 25'h1000000, 65536);
    testMean(600, 25'h0ABCDEF, 65536);
    testMean(75, 1, 8192);
    testMean(4091, 25'h1FFFFFF, 8192);
    testClearOnLoad();
    testNoClear();
    testHold();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYCLES, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule